// File: doc/BRIEF.md
# T1 Multiplexed Receive Backplane Serializer

This block gathers the received T1 frames of several framer channels and sends them out on one shared serial backplane bus. Every bus frame begins at the active transition of a frame-sync input. Each framer's frame is made of an F-bit slot and 24 channel octets. It is placed on the bus from a programmable channel offset, and its lanes are interleaved with the lanes of the other framers at a stride equal to the framer count. A per-framer bit shift of zero to seven bit times can also apply. Bus positions that no framer claims carry filler.

The block reads each framer through a byte-wide source. It presents the octet index it needs and takes back the octet, the signaling nibble and the F-bit. One bus bit goes out per clock cycle. A parity bit, accumulated over the framer's bits in the previous bus frame, can replace the F-bit on both the data and signaling outputs. A per-framer frame pulse marks where each framer's F position falls. Offsets and controls take effect only at a frame-sync boundary.

Top module: `t1_bp_serializer`

## Requirements
- R1: After reset, and before the first active sync transition, `ser_out` and `sig_out` are 1 and `fp_out` is all zero.
- R2: The active sync transition is rising when `fs_fall_sel`=0 and falling when it is 1. Number clock edges from 1, starting at the first rising edge that samples the new sync level. Bus position b is then driven from rising edge b+2.
- R3: Bus position p is 8*slot + bit, with bit 0 first. Framer k's item i lies in slot `chan_off[k]` + NUM_FRAMERS*i. Item 0 is the F slot: bit 0 carries the F value and bits 1..7 carry filler. Items 1..24 carry channel octets, MSB at bit 0. Positions at or past BUS_BITS are dropped.
- R4: When `bit_off_en[k]`=1 and `hi_rate`=0, all of framer k's positions move later by `bit_off[k]` positions. Positions pushed to BUS_BITS or beyond are dropped.
- R5: When `hi_rate`=1, no framer is shifted, whatever `bit_off_en` and `bit_off` hold.
- R6: A position that no framer claims drives 1 on `ser_out` and `sig_out`. When several framers claim one position, the lowest framer index drives it.
- R7: With `par_en`=1, the F value is P = X when `par_odd`=0 and P = not X when `par_odd`=1. X is the XOR of the framer's placed octet bits in the previous bus frame. In the first frame after reset, X is 0. With `par_en`=0, the F value is `fr_fbit[k]`.
- R8: With `par_incl_f`=1, the framer's source F-bit, when placed, is also folded into X. The inserted parity value is never folded in.
- R9: In a channel slot, `sig_out` carries filler at bits 0..3 and the nibble at bits 4..7, with `fr_sig[k][3]` first. At the F position, `sig_out` equals `ser_out`.
- R10: `fp_out[k]` is 1 exactly at framer k's F position (item 0, bit 0) and 0 elsewhere.
- R11: Offsets, shifts, `hi_rate` and the parity controls are captured at the active sync transition. Changes made later within a frame have no effect until the next sync.
- R12: Once BUS_BITS positions have gone by without a new sync, the outputs hold filler and `fp_out` is zero until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock, one bus position per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_in | input | 1 | Backplane frame sync |
| fs_fall_sel | input | 1 | 1 selects the falling sync transition, 0 the rising one |
| hi_rate | input | 1 | High-rate multiplexed bus; forces bit shifts off |
| chan_off | input | NUM_FRAMERS*OFF_W | Per-framer channel offset in slots |
| bit_off | input | NUM_FRAMERS*BOFF_W | Per-framer bit shift |
| bit_off_en | input | NUM_FRAMERS | Per-framer bit-shift enable |
| par_en | input | 1 | Replace the F value with parity |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| par_incl_f | input | 1 | Fold the source F-bit into the parity |
| fr_data | input | NUM_FRAMERS*8 | Octet for the index presented on fr_idx |
| fr_fbit | input | NUM_FRAMERS | Source F-bit of each framer |
| fr_sig | input | NUM_FRAMERS*4 | Signaling nibble for the index presented on fr_idx |
| fr_idx | output | NUM_FRAMERS*5 | Item index requested from each framer (0 = F slot) |
| ser_out | output | 1 | Serial bus data |
| sig_out | output | 1 | Serial bus signaling |
| fp_out | output | NUM_FRAMERS | Per-framer frame pulse at the F position |

## Verification
The bench goes after shifted lanes that run into the end of the bus frame. A design that wraps them or keeps them would put stray bits at the start of the frame or at the end. It sets shifts while `hi_rate` is high, where a design that ignored the override would move every lane. It stacks framers on the same slots, where broken priority gives the wrong octet. It toggles the parity mode and the F-bit inclusion from frame to frame and changes the data seed between frames. A design that used the current frame, or the inserted bit, in the parity would show a wrong F value. It also rewrites the offsets in the middle of a frame, where a design without capture at the sync boundary would tear the frame. It also runs frames on the falling sync edge, where a wrong edge choice shifts every position.

// File: rtl/bps_pkg.sv
// Shared constants and types for the backplane serializer.
// Assumes one T1 frame = F slot + 24 channel octets.
package bps_pkg;
    localparam int ITEMS     = 25;
    localparam int LAST_ITEM = ITEMS - 1;

    typedef logic [4:0] item_t;

    // Where one framer sits at the current bus position.
    typedef struct packed {
        logic       own;
        item_t      item;
        logic [2:0] bitp;
    } pos_t;
endpackage

// File: rtl/bps_frame_timer.sv
// Frame timer: detects the selected sync transition and counts bus
// positions from it. Assumes sync is synchronous to clk. The count
// parks at BUS_BITS (idle) until the next sync.
module bps_frame_timer #(
    parameter int BUS_BITS = 1024,
    parameter int CNT_W    = $clog2(BUS_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_in,
    input  logic             fs_fall_sel,
    output logic             frame_start,
    output logic [CNT_W-1:0] bit_cnt
);
    logic fs_q;
    logic fs_seen;

    // Purpose: keep the previous sync level; arm detection after one sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q    <= 1'b0;
            fs_seen <= 1'b0;
        end else begin
            fs_q    <= fs_in;
            fs_seen <= 1'b1;
        end
    end

    assign frame_start = fs_seen &&
                         (fs_fall_sel ? (fs_q && !fs_in) : (!fs_q && fs_in));

    // Purpose: bus position counter, restarted by sync, saturating at idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= CNT_W'(BUS_BITS);
        end else if (frame_start) begin
            bit_cnt <= '0;
        end else if (bit_cnt != CNT_W'(BUS_BITS)) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bps_slot_map.sv
// Slot mapper for one framer: from the bus position, the framer's channel
// offset and its bit shift, decides whether the framer owns the position
// and which item and bit it is. Assumes NUM_FRAMERS is a power of two >= 2.
module bps_slot_map
    import bps_pkg::*;
#(
    parameter int NUM_FRAMERS = 4,
    parameter int BUS_BITS    = 1024,
    parameter int CNT_W       = $clog2(BUS_BITS + 1),
    parameter int OFF_W       = 7,
    parameter int BOFF_W      = 3
) (
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [OFF_W-1:0]  chan_off,
    input  logic [BOFF_W-1:0] boff,
    input  logic              shift_en,
    output pos_t              pos
);
    localparam int NF_W   = $clog2(NUM_FRAMERS);
    localparam int SLOT_W = CNT_W - 3;
    localparam int EXT_W  = SLOT_W + OFF_W + 1;

    logic [CNT_W-1:0] shift;
    logic [CNT_W-1:0] p;
    logic [SLOT_W-1:0] slot;
    logic [EXT_W-1:0] rel;
    logic [EXT_W-1:0] grp;
    logic in_frame;
    logic above;
    logic lane_ok;

    assign shift    = shift_en ? CNT_W'(boff) : '0;
    assign in_frame = (bit_cnt < CNT_W'(BUS_BITS)) && (bit_cnt >= shift);
    assign p        = bit_cnt - shift;
    assign slot     = p[CNT_W-1:3];
    assign above    = EXT_W'(slot) >= EXT_W'(chan_off);
    assign rel      = EXT_W'(slot) - EXT_W'(chan_off);
    assign lane_ok  = (rel[NF_W-1:0] == '0);
    assign grp      = rel >> NF_W;

    // Purpose: assemble ownership, item index and bit index.
    always_comb begin
        pos.own  = in_frame && above && lane_ok && (grp <= EXT_W'(LAST_ITEM));
        pos.item = (grp <= EXT_W'(LAST_ITEM)) ? grp[4:0] : item_t'(LAST_ITEM);
        pos.bitp = p[2:0];
    end
endmodule

// File: rtl/bps_parity.sv
// Parity accumulator for one framer: folds in the framer's bits during a
// bus frame and hands the result over at the next sync, where it is held
// for insertion during the whole following frame.
module bps_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic acc_en,
    input  logic acc_bit,
    output logic held
);
    logic acc;

    // Purpose: accumulate during the frame, transfer and clear at sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= 1'b0;
            held <= 1'b0;
        end else if (frame_start) begin
            held <= acc;
            acc  <= 1'b0;
        end else if (acc_en) begin
            acc  <= acc ^ acc_bit;
        end
    end

    AST_HELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(held)); // R7
endmodule

// File: rtl/t1_bp_serializer.sv
// Backplane serializer top: captures configuration at each sync, maps
// every framer onto the bus, picks the lowest-index owner, inserts parity
// and registers data, signaling and frame pulses. Assumes fr_data/fr_sig
// answer fr_idx within the same cycle.
module t1_bp_serializer
    import bps_pkg::*;
#(
    parameter int NUM_FRAMERS = 4,
    parameter int BUS_BITS    = 1024,
    parameter int OFF_W       = 7,
    parameter int BOFF_W      = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                fs_in,
    input  logic                                fs_fall_sel,
    input  logic                                hi_rate,
    input  logic [NUM_FRAMERS-1:0][OFF_W-1:0]   chan_off,
    input  logic [NUM_FRAMERS-1:0][BOFF_W-1:0]  bit_off,
    input  logic [NUM_FRAMERS-1:0]              bit_off_en,
    input  logic                                par_en,
    input  logic                                par_odd,
    input  logic                                par_incl_f,
    input  logic [NUM_FRAMERS-1:0][7:0]         fr_data,
    input  logic [NUM_FRAMERS-1:0]              fr_fbit,
    input  logic [NUM_FRAMERS-1:0][3:0]         fr_sig,
    output logic [NUM_FRAMERS-1:0][4:0]         fr_idx,
    output logic                                ser_out,
    output logic                                sig_out,
    output logic [NUM_FRAMERS-1:0]              fp_out
);
    localparam int CNT_W = $clog2(BUS_BITS + 1);

    logic             frame_start;
    logic [CNT_W-1:0] bit_cnt;

    logic [NUM_FRAMERS-1:0][OFF_W-1:0]  cfg_off;
    logic [NUM_FRAMERS-1:0][BOFF_W-1:0] cfg_boff;
    logic [NUM_FRAMERS-1:0]             cfg_ben;
    logic cfg_hi;
    logic cfg_pen;
    logic cfg_podd;
    logic cfg_pinc;

    logic [NUM_FRAMERS-1:0] lane_own;
    logic [NUM_FRAMERS-1:0] lane_ser;
    logic [NUM_FRAMERS-1:0] lane_sig;
    logic [NUM_FRAMERS-1:0] lane_fp;
    logic ser_nxt;
    logic sig_nxt;

    bps_frame_timer #(.BUS_BITS(BUS_BITS), .CNT_W(CNT_W)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_in       (fs_in),
        .fs_fall_sel (fs_fall_sel),
        .frame_start (frame_start),
        .bit_cnt     (bit_cnt)
    );

    // Purpose: capture configuration only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_off  <= '0;
            cfg_boff <= '0;
            cfg_ben  <= '0;
            cfg_hi   <= 1'b0;
            cfg_pen  <= 1'b0;
            cfg_podd <= 1'b0;
            cfg_pinc <= 1'b0;
        end else if (frame_start) begin
            cfg_off  <= chan_off;
            cfg_boff <= bit_off;
            cfg_ben  <= bit_off_en;
            cfg_hi   <= hi_rate;
            cfg_pen  <= par_en;
            cfg_podd <= par_odd;
            cfg_pinc <= par_incl_f;
        end
    end

    for (genvar g = 0; g < NUM_FRAMERS; g++) begin : g_lane
        pos_t pos;
        logic held;
        logic fslot;
        logic dbit;
        logic fval;
        logic s_bit;
        logic q_bit;
        logic acc_en;
        logic acc_bit;

        bps_slot_map #(
            .NUM_FRAMERS (NUM_FRAMERS),
            .BUS_BITS    (BUS_BITS),
            .CNT_W       (CNT_W),
            .OFF_W       (OFF_W),
            .BOFF_W      (BOFF_W)
        ) map_i (
            .bit_cnt  (bit_cnt),
            .chan_off (cfg_off[g]),
            .boff     (cfg_boff[g]),
            .shift_en (cfg_ben[g] && !cfg_hi),
            .pos      (pos)
        );

        bps_parity par_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .acc_en      (acc_en),
            .acc_bit     (acc_bit),
            .held        (held)
        );

        // Purpose: bit values this framer would drive at the current position.
        always_comb begin
            fslot = (pos.item == '0);
            dbit  = fr_data[g][3'd7 - pos.bitp];
            fval  = cfg_pen ? (held ^ cfg_podd) : fr_fbit[g];
            if (fslot) begin
                s_bit = (pos.bitp == 3'd0) ? fval : 1'b1;
                q_bit = s_bit;
            end else begin
                s_bit = dbit;
                q_bit = pos.bitp[2] ? fr_sig[g][2'd3 - pos.bitp[1:0]] : 1'b1;
            end
            acc_en  = pos.own && (!fslot || ((pos.bitp == 3'd0) && cfg_pinc));
            acc_bit = fslot ? fr_fbit[g] : dbit;
        end

        assign lane_own[g] = pos.own;
        assign lane_ser[g] = s_bit;
        assign lane_sig[g] = q_bit;
        assign lane_fp[g]  = pos.own && fslot && (pos.bitp == 3'd0);
        assign fr_idx[g]   = pos.item;
    end

    // Purpose: lowest-index owner drives the bus; filler otherwise.
    always_comb begin
        ser_nxt = 1'b1;
        sig_nxt = 1'b1;
        for (int k = NUM_FRAMERS - 1; k >= 0; k--) begin
            if (lane_own[k]) begin
                ser_nxt = lane_ser[k];
                sig_nxt = lane_sig[k];
            end
        end
    end

    // Purpose: register the bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b1;
            sig_out <= 1'b1;
            fp_out  <= '0;
        end else begin
            ser_out <= ser_nxt;
            sig_out <= sig_nxt;
            fp_out  <= lane_fp;
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (bit_cnt == '0)); // R2
    AST_IDLE_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_W'(BUS_BITS)) |=> (ser_out && sig_out && (fp_out == '0))); // R12
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(cfg_off) && $stable(cfg_boff) && $stable(cfg_pen))); // R11
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_cnt == CNT_W'(BUS_BITS)) && !frame_start) |=> (bit_cnt == CNT_W'(BUS_BITS))); // R12
endmodule

// File: tb/t1_bp_serializer_tb_top.sv
`timescale 1ns/1ps
module t1_bp_serializer_tb_top;
    localparam int NF = 4;
    localparam int BB = 1024;
    localparam int OW = 7;
    localparam int BW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, fs_in, fs_fall_sel, hi_rate, par_en, par_odd, par_incl_f;
    logic [NF-1:0][OW-1:0] chan_off;
    logic [NF-1:0][BW-1:0] bit_off;
    logic [NF-1:0]         bit_off_en;
    logic [NF-1:0][7:0]    fr_data;
    logic [NF-1:0]         fr_fbit;
    logic [NF-1:0][3:0]    fr_sig;
    logic [NF-1:0][4:0]    fr_idx;
    logic                  ser_out, sig_out;
    logic [NF-1:0]         fp_out;

    t1_bp_serializer #(.NUM_FRAMERS(NF), .BUS_BITS(BB), .OFF_W(OW), .BOFF_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .fs_fall_sel(fs_fall_sel),
        .hi_rate(hi_rate), .chan_off(chan_off), .bit_off(bit_off),
        .bit_off_en(bit_off_en), .par_en(par_en), .par_odd(par_odd),
        .par_incl_f(par_incl_f), .fr_data(fr_data), .fr_fbit(fr_fbit),
        .fr_sig(fr_sig), .fr_idx(fr_idx), .ser_out(ser_out),
        .sig_out(sig_out), .fp_out(fp_out)
    );

    typedef struct {
        int            cyc;
        logic          ser;
        logic          sig;
        logic [NF-1:0] fp;
        string         tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int seed = 1;
    logic [NF-1:0] prev_acc = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] dat_fn(int sd, int k, int it);
        return 8'((sd * 37 + k * 53 + it * 11 + 5) ^ (it * 8));
    endfunction

    function automatic logic [3:0] sig_fn(int sd, int k, int it);
        return 4'(sd + k * 3 + it * 5);
    endfunction

    // Framer sources answer the requested index at once.
    always_comb begin
        for (int k = 0; k < NF; k++) begin
            fr_data[k] = dat_fn(seed, k, int'(fr_idx[k]));
            fr_sig[k]  = sig_fn(seed, k, int'(fr_idx[k]));
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected items when their cycle comes due.
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            e = q.pop_front();
            chk(e.cyc == cyc, "R2", 32'(cyc), 32'(e.cyc));
            chk(ser_out === e.ser, e.tag, 32'(ser_out), 32'(e.ser));
            chk(sig_out === e.sig, "R9", 32'(sig_out), 32'(e.sig));
            chk(fp_out === e.fp, "R10", 32'(fp_out), 32'(e.fp));
        end
    end

    // Driver side: reference model of one bus frame pushed into the queue.
    task automatic build_expected(input string tag, input int c0);
        logic          es[BB];
        logic          eg[BB];
        logic [NF-1:0] ef[BB];
        logic [NF-1:0] new_acc;
        exp_t          e;
        for (int p = 0; p < BB; p++) begin
            es[p] = 1'b1; eg[p] = 1'b1; ef[p] = '0;
        end
        new_acc = '0;
        for (int k = NF - 1; k >= 0; k--) begin
            int   sh;
            logic acc;
            logic fval;
            sh   = (bit_off_en[k] && !hi_rate) ? int'(bit_off[k]) : 0;
            acc  = 1'b0;
            fval = par_en ? (prev_acc[k] ^ par_odd) : fr_fbit[k];
            for (int it = 0; it < 25; it++) begin
                for (int b = 0; b < 8; b++) begin
                    int pos;
                    pos = (int'(chan_off[k]) + NF * it) * 8 + b + sh;
                    if (pos < BB) begin
                        logic sb, gb;
                        logic [7:0] d;
                        logic [3:0] s;
                        d = dat_fn(seed, k, it);
                        s = sig_fn(seed, k, it);
                        if (it == 0) begin
                            sb = (b == 0) ? fval : 1'b1;
                            gb = sb;
                            if (b == 0) begin
                                ef[pos][k] = 1'b1;
                                if (par_incl_f) acc ^= fr_fbit[k];
                            end
                        end else begin
                            sb = d[7 - b];
                            gb = (b >= 4) ? s[7 - b] : 1'b1;
                            acc ^= sb;
                        end
                        es[pos] = sb;
                        eg[pos] = gb;
                    end
                end
            end
            new_acc[k] = acc;
        end
        prev_acc = new_acc;
        for (int p = 0; p < BB; p++) begin
            e.cyc = c0 + 2 + p; e.ser = es[p]; e.sig = eg[p]; e.fp = ef[p]; e.tag = tag;
            q.push_back(e);
        end
        for (int p = 0; p < 4; p++) begin
            e.cyc = c0 + 2 + BB + p; e.ser = 1'b1; e.sig = 1'b1; e.fp = '0; e.tag = "R12";
            q.push_back(e);
        end
    endtask

    task automatic run_frame(input string tag, input bit mid);
        @(posedge clk); #1;
        fs_in = fs_fall_sel ? 1'b1 : 1'b0;
        repeat (2) @(posedge clk);
        #1;
        build_expected(tag, cyc);
        fs_in = fs_fall_sel ? 1'b0 : 1'b1;
        if (mid) begin
            repeat (300) @(posedge clk);
            #1;
            for (int k = 0; k < NF; k++) begin
                chan_off[k] = chan_off[k] + 7'd5;
                bit_off[k]  = 3'd6;
            end
            bit_off_en = '1;
            par_en     = ~par_en;
            repeat (BB + 8 - 300) @(posedge clk);
        end else begin
            repeat (BB + 8) @(posedge clk);
        end
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fs_in = 1'b0; fs_fall_sel = 1'b0; hi_rate = 1'b0;
        par_en = 1'b0; par_odd = 1'b0; par_incl_f = 1'b0;
        for (int k = 0; k < NF; k++) begin
            chan_off[k] = OW'(k);
            bit_off[k]  = '0;
        end
        bit_off_en = '0;
        fr_fbit    = 4'b1010;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle filler after reset, no sync yet
        repeat (6) begin
            @(negedge clk);
            chk(ser_out === 1'b1 && sig_out === 1'b1 && fp_out === '0, "R1",
                {30'd0, ser_out, sig_out}, 32'h3);
        end

        // R3: base layout, offsets 0..3
        run_frame("R3", 1'b0);

        // R7: even parity over the previous frame, new data
        seed = 2; fr_fbit = 4'b0101; par_en = 1'b1; par_odd = 1'b0;
        run_frame("R7", 1'b0);
        seed = 3; par_odd = 1'b1;
        run_frame("R7", 1'b0);

        // R8: source F-bit folded into parity
        seed = 4; par_incl_f = 1'b1; fr_fbit = 4'b1100;
        run_frame("R8", 1'b0);
        seed = 5; par_odd = 1'b0;
        run_frame("R8", 1'b0);

        // R4: bit shifts with overlapping neighbours
        seed = 6; par_en = 1'b0; bit_off_en = '1;
        bit_off[0] = 3'd2; bit_off[1] = 3'd5; bit_off[2] = 3'd0; bit_off[3] = 3'd7;
        run_frame("R4", 1'b0);

        // R4: far offsets; late lanes run off the end and are dropped
        chan_off[0] = 7'd0; chan_off[1] = 7'd33; chan_off[2] = 7'd66; chan_off[3] = 7'd99;
        bit_off[0] = 3'd1; bit_off[1] = 3'd2; bit_off[2] = 3'd3; bit_off[3] = 3'd4;
        run_frame("R4", 1'b0);

        // R5: high-rate mode forces shifts off
        hi_rate = 1'b1;
        run_frame("R5", 1'b0);

        // R6: stacked framers, lowest index wins
        hi_rate = 1'b0; bit_off_en = '0;
        chan_off[0] = 7'd0; chan_off[1] = 7'd0; chan_off[2] = 7'd8; chan_off[3] = 7'd1;
        run_frame("R6", 1'b0);

        // R2: falling sync edge, then back to rising
        for (int k = 0; k < NF; k++) chan_off[k] = OW'(k);
        seed = 9; par_en = 1'b1; fs_fall_sel = 1'b1;
        run_frame("R2", 1'b0);
        fs_fall_sel = 1'b0; seed = 10;
        run_frame("R2", 1'b0);

        // R11: mid-frame rewrite must not disturb the running frame
        seed = 7;
        run_frame("R11", 1'b1);
        seed = 8;
        run_frame("R11", 1'b0);

        chk(q.size() == 0, "R12", 32'(q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule